// File: doc/BRIEF.md
# Caption Decoder Interrupt Controller

This block gathers the interrupt sources of a line-21 caption and extended-data decoder into one byte-wide request register, a matching mask register and a single level interrupt line. Five change-of-state events can be raised: lock state, selected-channel activity, extended-data activity, caption activity and text activity. Each one arrives as a one-cycle strobe and sets a sticky request bit. The host clears a sticky bit by writing a one to it.

Two more request bits report video timing: end of field and end of the data line. The hardware sets them on their strobes and clears them by itself when the line counter reaches a fixed row past row 15. Host writes have no effect on these two bits. The lowest mask bit enables a separate data-available level input instead of a request bit. The interrupt line is high while any enabled source is active.

Top module: `caption_irq_ctrl`

## Requirements
- R1: After reset the request register at address 0x06 reads 0x00, the mask register at address 0x07 reads 0x00, and irq_o is low.
- R2: A strobe on evt_i[k] sets request bit 3+k at the next clock edge. The mapping is k=0 lock, 1 selected channel, 2 extended data, 3 caption, 4 text. The bit then stays set until the host clears it.
- R3: A write to 0x06 clears each of the request bits 7..3 where wdata_i holds a 1. Bits where wdata_i holds a 0 are left unchanged.
- R4: When a strobe and a write-one-to-clear hit the same request bit in the same cycle, the bit stays set.
- R5: eof_i sets request bit 2 and dle_i sets request bit 1 at the next edge. Host writes never change bits 2 and 1.
- R6: Bits 2 and 1 clear at the edge that ends a cycle in which line_i equals 15 + CLR_OFFSET. If a strobe arrives in that same cycle, its bit is set instead of cleared.
- R7: Bit 0 of the request register always reads 0. Any address other than 0x06 or 0x07 reads 0x00.
- R8: All eight mask bits at 0x07 are writable and read back as written, from the edge after the write.
- R9: irq_o is high in the same cycle whenever (request[7:1] & mask[7:1]) is nonzero, or when mask[0] and dav_i are both 1. Otherwise it is low.
- R10: While the mask register is 0x00, irq_o stays low whatever the requests and dav_i are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| evt_i | input | 5 | Change-of-state event strobes |
| eof_i | input | 1 | End-of-field strobe |
| dle_i | input | 1 | Data-line-ended strobe |
| line_i | input | LINE_W | Current video line count |
| dav_i | input | 1 | Data-available level |
| irq_o | output | 1 | Interrupt, level, active high |

## Verification
The bench builds the block with LINE_W=6 and CLR_OFFSET=2, so the auto-clear row is line 17. A short line sweep therefore reaches the row just before the clear point and the clear point itself, and can also make a strobe coincide with the clear. ADDR_W stays at 8. This lets the bench probe an unmapped neighbour address beside the two live registers.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned N_EVT    = 5;
  localparam int unsigned EVT_LSB  = 3;
  localparam int unsigned EOF_BIT  = 2;
  localparam int unsigned DLE_BIT  = 1;
  localparam int unsigned ROW_BASE = 15;
  localparam logic [7:0]  ADDR_REQ  = 8'h06;
  localparam logic [7:0]  ADDR_MASK = 8'h07;
endpackage

// File: rtl/cirq_sticky_bank.sv
module cirq_sticky_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;   // event beats clear
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/cirq_field_status.sv
module cirq_field_status #(
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned CLR_LINE = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eof_i,
  input  logic              dle_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              eof_o,
  output logic              dle_o
);
  localparam logic [LINE_W-1:0] ClrLine = LINE_W'(CLR_LINE);
  logic at_clr;
  assign at_clr = (line_i == ClrLine);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eof_o <= 1'b0;
      dle_o <= 1'b0;
    end else begin
      if (eof_i)       eof_o <= 1'b1;
      else if (at_clr) eof_o <= 1'b0;
      if (dle_i)       dle_o <= 1'b1;
      else if (at_clr) dle_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cirq_irq_combine.sv
module cirq_irq_combine #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] mask_i,
  input  logic         dav_i,
  output logic         irq_o
);
  logic [W-1:0] hit;
  for (genvar g = 0; g < W; g++) begin : g_src
    if (g == 0) begin : g_dav
      assign hit[g] = mask_i[g] & dav_i;  // bit 0 enables the data-available level
    end else begin : g_req
      assign hit[g] = mask_i[g] & req_i[g];
    end
  end
  assign irq_o = |hit;
endmodule

// File: rtl/caption_irq_ctrl.sv
module caption_irq_ctrl
  import cirq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned CLR_OFFSET = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [4:0]        evt_i,
  input  logic              eof_i,
  input  logic              dle_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              dav_i,
  output logic              irq_o
);
  localparam int unsigned CLR_LINE = ROW_BASE + CLR_OFFSET;
  localparam logic [ADDR_W-1:0] AReq  = ADDR_W'(ADDR_REQ);
  localparam logic [ADDR_W-1:0] AMask = ADDR_W'(ADDR_MASK);

  logic             sel_req, sel_mask;
  logic [N_EVT-1:0] evt_q, evt_clr;
  logic             eof_q, dle_q;
  logic [REG_W-1:0] mask_q, req_vec;

  assign sel_req  = (addr_i == AReq);
  assign sel_mask = (addr_i == AMask);
  assign evt_clr  = (wr_en_i && sel_req) ? wdata_i[EVT_LSB +: N_EVT] : '0;

  cirq_sticky_bank #(.N(N_EVT)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (evt_clr),
    .q_o   (evt_q)
  );

  cirq_field_status #(.LINE_W(LINE_W), .CLR_LINE(CLR_LINE)) u_field (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .eof_i (eof_i),
    .dle_i (dle_i),
    .line_i(line_i),
    .eof_o (eof_q),
    .dle_o (dle_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mask_q <= '0;
    else if (wr_en_i && sel_mask) mask_q <= wdata_i;
  end

  always_comb begin
    req_vec          = '0;
    req_vec[EVT_LSB +: N_EVT] = evt_q;
    req_vec[EOF_BIT] = eof_q;
    req_vec[DLE_BIT] = dle_q;
  end

  always_comb begin
    if (sel_req)       rdata_o = req_vec;
    else if (sel_mask) rdata_o = mask_q;
    else               rdata_o = '0;
  end

  cirq_irq_combine #(.W(REG_W)) u_irq (
    .req_i (req_vec),
    .mask_i(mask_q),
    .dav_i (dav_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned CLR_LINE = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [4:0]        evt_i,
  input logic              eof_i,
  input logic              dle_i,
  input logic [LINE_W-1:0] line_i,
  input logic [7:0]        req_i,
  input logic [7:0]        mask_i,
  input logic              irq_o
);
  localparam logic [LINE_W-1:0] ClrLine = LINE_W'(CLR_LINE);
  localparam logic [ADDR_W-1:0] AReq    = ADDR_W'(8'h06);

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((req_i[7:3] & $past(evt_i)) == $past(evt_i)));

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AReq) |=> ((req_i[7:3] & $past(wdata_i[7:3] & ~evt_i)) == 5'b0));

  a_r5_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eof_i && !dle_i && line_i != ClrLine) |=> $stable(req_i[2:1]));

  a_r6_row_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == ClrLine && !eof_i && !dle_i) |=> (req_i[2:1] == 2'b00));

  a_r7_bit0_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AReq) |-> !rdata_o[0]);

  a_r9_no_src_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i[7:1] & mask_i[7:1]) == 7'b0 && !mask_i[0]) |-> !irq_o);

  a_r10_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == 8'h00) |-> !irq_o);
endmodule

bind caption_irq_ctrl cirq_checker #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CLR_LINE(CLR_LINE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .eof_i(eof_i),
  .dle_i(dle_i), .line_i(line_i), .req_i(req_vec), .mask_i(mask_q),
  .irq_o(irq_o)
);

// File: tb/caption_irq_ctrl_tb.sv
module caption_irq_ctrl_tb;
  localparam int LW = 6;
  localparam int CLR = 17;

  logic          clk = 0, rst_n = 0;
  logic [7:0]    addr = 0, wdata = 0;
  logic          we = 0, eof = 0, dle = 0, dav = 0;
  logic [4:0]    evt = 0;
  logic [LW-1:0] line = 0;
  logic [7:0]    rdata;
  logic          irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] m_req = 0, m_mask = 0;

  always #4 clk = ~clk;

  caption_irq_ctrl #(.ADDR_W(8), .LINE_W(LW), .CLR_OFFSET(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .eof_i(eof), .dle_i(dle), .line_i(line),
    .dav_i(dav), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_mask = 0;
    end else begin
      logic [7:0] n;
      n = m_req;
      if (we && addr == 8'h06) for (int b = 3; b < 8; b++) if (wdata[b]) n[b] = 0;
      if (we && addr == 8'h07) m_mask = wdata;
      if (int'(line) == CLR) begin n[2] = 0; n[1] = 0; end
      for (int k = 0; k < 5; k++) if (evt[k]) n[3+k] = 1;
      if (eof) n[2] = 1;
      if (dle) n[1] = 1;
      m_req = n;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h06) return m_req;
    if (a == 8'h07) return m_mask;
    return 8'h00;
  endfunction

  // compare every cycle
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic e_irq;
      e_irq = (|(m_req[7:1] & m_mask[7:1])) | (m_mask[0] & dav);
      chk(irq === e_irq, "R9 irq", irq, e_irq);
      chk(rdata === exp_rd(addr), addr == 8'h07 ? "R8 rdata" : "R7 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic [4:0] e, input logic eo, input logic dl, input int ln);
    @(negedge clk);
    addr = a; we = w; wdata = d; evt = e; eof = eo; dle = dl; line = LW'(ln);
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; we = 0; wdata = 0; evt = 0; eof = 0; dle = 0; line = 0;
    #2 chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic peek_irq(input logic dv, input logic exp, input string tag);
    @(negedge clk);
    we = 0; evt = 0; eof = 0; dle = 0; line = 0; dav = dv;
    #2 chk(irq === exp, tag, irq, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(irq === 1'b0, "R1 irq", irq, 0);
    rst_n = 1;
    peek(8'h06, 8'h00, "R1 req");
    peek(8'h07, 8'h00, "R1 mask");
    step(8'h06, 0, 0, 5'h1F, 0, 0, 0);
    peek(8'h06, 8'hF8, "R2 all events");
    peek_irq(1, 0, "R10 mask zero");
    peek_irq(0, 0, "R10 mask zero");
    step(8'h06, 1, 8'h28, 0, 0, 0, 0);
    peek(8'h06, 8'hD0, "R3 partial clear");
    step(8'h06, 1, 8'h00, 0, 0, 0, 0);
    peek(8'h06, 8'hD0, "R3 zero write");
    step(8'h06, 1, 8'hFF, 5'h10, 0, 0, 0);
    peek(8'h06, 8'h80, "R4 event wins");
    step(8'h06, 0, 0, 0, 1, 1, 0);
    peek(8'h06, 8'h86, "R5 status set");
    step(8'h06, 1, 8'h06, 0, 0, 0, 0);
    peek(8'h06, 8'h86, "R5 write ignored");
    step(8'h06, 0, 0, 0, 0, 0, CLR - 1);
    peek(8'h06, 8'h86, "R6 before row");
    step(8'h06, 0, 0, 0, 0, 0, CLR);
    peek(8'h06, 8'h80, "R6 row clear");
    step(8'h06, 0, 0, 0, 1, 0, CLR);
    peek(8'h06, 8'h84, "R6 set beats clear");
    step(8'h06, 1, 8'hFF, 0, 0, 0, 0);
    peek(8'h06, 8'h04, "R3 clear all");
    step(8'h06, 0, 0, 5'h01, 0, 0, 0);
    peek(8'h06, 8'h0C, "R2 lock bit");
    peek(8'h05, 8'h00, "R7 unmapped");
    step(8'h06, 1, 8'h01, 0, 0, 0, 0);
    peek(8'h06, 8'h0C, "R7 bit0 zero");
    step(8'h07, 1, 8'hA5, 0, 0, 0, 0);
    peek(8'h07, 8'hA5, "R8 mask readback");
    peek_irq(0, 1, "R9 eof enabled");
    step(8'h07, 1, 8'h01, 0, 0, 0, 0);
    peek_irq(0, 0, "R9 dav low");
    peek_irq(1, 1, "R9 dav high");
    step(8'h07, 1, 8'h00, 0, 0, 0, 0);
    peek_irq(1, 0, "R10 mask cleared");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule